// File: doc/BRIEF.md
# Packet Buffer Slot Allocator

This block tracks which fixed-size slots of a packet buffer are in use. Each slot is 2048 bytes, and the block keeps one occupancy bit for each slot. When the receive path asks for room to store a packet, the block finds the lowest-numbered free slot. It marks that slot as used and returns the slot's byte address in the same cycle. If every slot is taken, it reports a full condition instead.

Slots are given back over two independent release ports. Port 0 serves the internal discard path and port 1 serves the transmit-complete path. A fixed-priority arbiter lets one release reach the bitmap per cycle, so each accepted release clears exactly one bit.

A release that names a slot which is already free is rejected and latches an error flag. So is a release whose address does not name a slot at all.

Top module: `pktbuf_slot_alloc`

## Requirements
- R1: After a synchronous active-low reset every slot is free, `free_count` equals NUM_SLOTS (64 by default), `err_flag` is 0 and `alloc_full` is 0.
- R2: An allocation handshake (`alloc_valid` high while `alloc_ready` is high) with a free slot available returns `alloc_addr` = lowest free slot index × 2048 (index shifted left by 11) with `alloc_full` 0. That slot is marked used from the next cycle.
- R3: When no slot is free, an allocation handshake returns `alloc_full` = 1 in the same cycle and claims nothing; `free_count` stays 0.
- R4: `free_count` always equals the number of free slots and moves by exactly one per claim or accepted release.
- R5: An accepted release on either port, whose address is a slot index × 2048 of an occupied slot, frees that one slot, which is then returned again by a later allocation.
- R6: If both release ports are valid in one cycle, port 0 is accepted (`rel0_ready` = 1) and `rel1_ready` is 0. Port 1, holding its request, is accepted in a later cycle.
- R7: An allocation and an accepted release in the same cycle both take effect. The slot freed in that cycle is never the one returned by that cycle's allocation.
- R8: A release naming an already-free slot, an address whose low 11 offset bits are not zero, or an address beyond the last slot leaves every occupancy bit and `free_count` unchanged and sets `err_flag`.
- R9: `err_flag`, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation accepted (always high) |
| alloc_addr | output | ADDR_W | Byte address of the granted slot |
| alloc_full | output | 1 | No free slot; the request claims nothing |
| rel0_valid | input | 1 | Discard-path release request |
| rel0_ready | output | 1 | Discard-path release accepted |
| rel0_addr | input | ADDR_W | Byte address of the slot to release (port 0) |
| rel1_valid | input | 1 | Transmit-complete release request |
| rel1_ready | output | 1 | Transmit-complete release accepted |
| rel1_addr | input | ADDR_W | Byte address of the slot to release (port 1) |
| free_count | output | CNT_W | Number of free slots |
| err_flag | output | 1 | Sticky bad-release indicator |

## Verification
Several properties are checked on every cycle. The free counter must match the number of zero bits in the occupancy map. A granted slot must be free before the grant and marked used after it. A full report must only occur with a zero count. Port 1 must be held off whenever port 0 is also valid, and the error flag must never clear on its own.

Other behaviour can only be shown by the bench's scenarios. These include the lowest-first address order, reuse of a released slot, the hold-and-retry of port 1, and the same-cycle alloc/release ordering. They also include the proof that bad releases leave the map untouched, which the bench observes through later allocation results.

// File: rtl/slot_alloc_pkg.sv
// Shared definitions for the packet buffer slot allocator.
// Assumes nothing beyond IEEE 1800-2017 package semantics.
package slot_alloc_pkg;

    // Which release port the arbiter granted in a cycle.
    typedef enum logic [1:0] {
        GRANT_NONE    = 2'd0,
        GRANT_DISCARD = 2'd1,
        GRANT_TXDONE  = 2'd2
    } rel_grant_e;

    // Slot size in bytes is 2**SLOT_SHIFT_DEFAULT.
    localparam int SLOT_SHIFT_DEFAULT = 11;

endpackage

// File: rtl/slot_prio_enc.sv
// Lowest-free-slot priority encoder.
// Given the occupancy map (1 = used), reports whether any slot is free and
// the index of the lowest-numbered free one. Purely combinational.
// Assumes IDX_W is wide enough to hold NUM_SLOTS-1.
module slot_prio_enc #(
    parameter int NUM_SLOTS = 64,
    parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] occ,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    // Scan from the top down so the lowest clear bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rel_arbiter.sv
// Fixed-priority arbiter and address decoder for the two release ports.
// Port 0 (discard) always wins; port 1 (transmit done) is held off while
// port 0 is valid. Each source must hold its request until accepted.
// The granted address is split into a slot index plus a malformed flag
// (nonzero offset bits, or a slot index beyond the last slot).
module rel_arbiter
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS  = 64,
    parameter int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    parameter int ADDR_W     = 32,
    parameter int SLOT_SHIFT = SLOT_SHIFT_DEFAULT
) (
    input  logic              v0,
    input  logic [ADDR_W-1:0] a0,
    output logic              r0,
    input  logic              v1,
    input  logic [ADDR_W-1:0] a1,
    output logic              r1,
    output logic              take,
    output logic [IDX_W-1:0]  take_idx,
    output logic              take_bad
);

    localparam int HI_LSB = SLOT_SHIFT + IDX_W;

    rel_grant_e        grant;
    logic [ADDR_W-1:0] sel_addr;
    logic              off_nz;
    logic              hi_nz;
    logic              idx_oor;

    // Pick the winning port.
    always_comb begin
        if (v0)      grant = GRANT_DISCARD;
        else if (v1) grant = GRANT_TXDONE;
        else         grant = GRANT_NONE;
    end

    // Ready outputs follow the grant.
    assign r0   = 1'b1;
    assign r1   = (grant != GRANT_DISCARD);
    assign take = (grant != GRANT_NONE);

    // Mux the granted address.
    assign sel_addr = (grant == GRANT_TXDONE) ? a1 : a0;

    // Split the address into offset, index and upper bits.
    assign off_nz   = |sel_addr[SLOT_SHIFT-1:0];
    assign take_idx = sel_addr[SLOT_SHIFT +: IDX_W];

    generate
        if (HI_LSB < ADDR_W) begin : g_hi
            assign hi_nz = |sel_addr[ADDR_W-1:HI_LSB];
        end else begin : g_no_hi
            assign hi_nz = 1'b0;
        end
    endgenerate

    // Flag indices past the last slot when NUM_SLOTS is not a power of two.
    always_comb begin
        idx_oor = (int'(take_idx) >= NUM_SLOTS);
    end

    assign take_bad = off_nz | hi_nz | idx_oor;

endmodule

// File: rtl/slot_map.sv
// Occupancy bitmap, free-slot counter and sticky error flag.
// Applies at most one claim and one release per cycle. The claim index must
// point at a free slot. A release is applied only when it names a used slot
// and is not malformed; otherwise the map is untouched and the error latches.
module slot_map #(
    parameter int NUM_SLOTS = 64,
    parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IDX_W-1:0]     set_idx,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic                 clr_bad,
    output logic [NUM_SLOTS-1:0] occ,
    output logic [CNT_W-1:0]     count,
    output logic                 err
);

    logic                 clr_ok;
    logic [NUM_SLOTS-1:0] set_mask;
    logic [NUM_SLOTS-1:0] clr_mask;
    logic [CNT_W-1:0]     count_nx;

    // A release is valid only for a well-formed address of an occupied slot.
    assign clr_ok = clr_en && !clr_bad && occ[clr_idx];

    // One-hot masks for the claim and the release.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_en) set_mask[set_idx] = 1'b1;
        if (clr_ok) clr_mask[clr_idx] = 1'b1;
    end

    // Next free count: minus one per claim, plus one per accepted release.
    always_comb begin
        count_nx = count;
        if (set_en && !clr_ok)      count_nx = count - CNT_W'(1);
        else if (!set_en && clr_ok) count_nx = count + CNT_W'(1);
    end

    // State update for the map, counter and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ   <= '0;
            count <= CNT_W'(NUM_SLOTS);
            err   <= 1'b0;
        end else begin
            occ   <= (occ | set_mask) & ~clr_mask;
            count <= count_nx;
            if (clr_en && !clr_ok) err <= 1'b1;
        end
    end

endmodule

// File: rtl/pktbuf_slot_alloc.sv
// Packet buffer slot allocator: top level.
// Grants the lowest free 2**SLOT_SHIFT-byte slot in the cycle of the request.
// Takes back released slots from two fixed-priority ports, and keeps a
// free-slot count. Allocation is always ready; the full case answers in the
// same handshake. Assumes release sources hold valid until accepted.
module pktbuf_slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS  = 64,
    parameter int ADDR_W     = 32,
    parameter int SLOT_SHIFT = SLOT_SHIFT_DEFAULT,
    parameter int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    parameter int CNT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    output logic [ADDR_W-1:0] alloc_addr,
    output logic              alloc_full,
    input  logic              rel0_valid,
    output logic              rel0_ready,
    input  logic [ADDR_W-1:0] rel0_addr,
    input  logic              rel1_valid,
    output logic              rel1_ready,
    input  logic [ADDR_W-1:0] rel1_addr,
    output logic [CNT_W-1:0]  free_count,
    output logic              err_flag
);

    logic [NUM_SLOTS-1:0] occ_map;
    logic                 any_free;
    logic [IDX_W-1:0]     win_idx;
    logic                 rel_take;
    logic [IDX_W-1:0]     rel_idx;
    logic                 rel_bad;

    // Find the lowest free slot in the current map.
    slot_prio_enc #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_enc (
        .occ   (occ_map),
        .found (any_free),
        .idx   (win_idx)
    );

    // Serialise the two release sources.
    rel_arbiter #(
        .NUM_SLOTS  (NUM_SLOTS),
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W),
        .SLOT_SHIFT (SLOT_SHIFT)
    ) u_arb (
        .v0       (rel0_valid),
        .a0       (rel0_addr),
        .r0       (rel0_ready),
        .v1       (rel1_valid),
        .a1       (rel1_addr),
        .r1       (rel1_ready),
        .take     (rel_take),
        .take_idx (rel_idx),
        .take_bad (rel_bad)
    );

    // Hold the bitmap, counter and error state.
    slot_map #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (alloc_valid && any_free),
        .set_idx (win_idx),
        .clr_en  (rel_take),
        .clr_idx (rel_idx),
        .clr_bad (rel_bad),
        .occ     (occ_map),
        .count   (free_count),
        .err     (err_flag)
    );

    // Allocation response, valid in the request cycle.
    assign alloc_ready = 1'b1;
    assign alloc_full  = !any_free;
    assign alloc_addr  = ADDR_W'(win_idx) << SLOT_SHIFT;

endmodule

// File: rtl/pktbuf_slot_alloc_chk.sv
// Property checker for pktbuf_slot_alloc, attached by bind.
// Observes the occupancy map, the granted index and the port handshakes.
module pktbuf_slot_alloc_chk #(
    parameter int NUM_SLOTS = 64,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_valid,
    input logic                 alloc_full,
    input logic [IDX_W-1:0]     win_idx,
    input logic [NUM_SLOTS-1:0] occ_map,
    input logic [CNT_W-1:0]     free_count,
    input logic                 err_flag,
    input logic                 rel0_valid,
    input logic                 rel0_ready,
    input logic                 rel1_valid,
    input logic                 rel1_ready
);

    // R4: counter equals the number of clear bits.
    a_r4_count_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_count) == NUM_SLOTS - $countones(occ_map));

    // R2: a granted slot is free at the grant.
    a_r2_grant_is_free: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_full) |-> !occ_map[win_idx]);

    // R2: a granted slot is marked used afterwards.
    a_r2_grant_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_full) |=> occ_map[$past(win_idx)]);

    // R3: full is reported only with no free slot.
    a_r3_full_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_full |-> (free_count == '0));

    // R3: a full request leaves the count at zero.
    a_r3_full_claims_none: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_full && !rel0_valid && !rel1_valid) |=> (free_count == '0));

    // R6: port 1 waits while port 0 is valid; port 0 always accepted.
    a_r6_port1_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rel0_valid && rel1_valid) |-> (rel0_ready && !rel1_ready));

    // R9: error flag is sticky.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind pktbuf_slot_alloc pktbuf_slot_alloc_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_full  (alloc_full),
    .win_idx     (win_idx),
    .occ_map     (occ_map),
    .free_count  (free_count),
    .err_flag    (err_flag),
    .rel0_valid  (rel0_valid),
    .rel0_ready  (rel0_ready),
    .rel1_valid  (rel1_valid),
    .rel1_ready  (rel1_ready)
);

// File: tb/tb_pktbuf_slot_alloc.sv
// Directed bench for pktbuf_slot_alloc, one task per scenario.
module tb_pktbuf_slot_alloc;

    localparam int N     = 64;
    localparam int AW    = 32;
    localparam int SH    = 11;
    localparam int CW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic          alloc_ready;
    logic [AW-1:0] alloc_addr;
    logic          alloc_full;
    logic          rel0_valid = 1'b0;
    logic          rel0_ready;
    logic [AW-1:0] rel0_addr = '0;
    logic          rel1_valid = 1'b0;
    logic          rel1_ready;
    logic [AW-1:0] rel1_addr = '0;
    logic [CW-1:0] free_count;
    logic          err_flag;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pktbuf_slot_alloc #(.NUM_SLOTS(N), .ADDR_W(AW), .SLOT_SHIFT(SH)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_addr(alloc_addr), .alloc_full(alloc_full),
        .rel0_valid(rel0_valid), .rel0_ready(rel0_ready), .rel0_addr(rel0_addr),
        .rel1_valid(rel1_valid), .rel1_ready(rel1_ready), .rel1_addr(rel1_addr),
        .free_count(free_count), .err_flag(err_flag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One allocation cycle; returns the same-cycle response.
    task automatic alloc_one(output logic [AW-1:0] addr, output logic full);
        @(negedge clk);
        alloc_valid = 1'b1;
        #1;
        addr = alloc_addr;
        full = alloc_full;
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
    endtask

    // Release on a port, holding valid until accepted.
    task automatic release_on(input int port, input logic [AW-1:0] addr);
        bit ok;
        @(negedge clk);
        if (port == 0) begin rel0_valid = 1'b1; rel0_addr = addr; end
        else           begin rel1_valid = 1'b1; rel1_addr = addr; end
        do begin
            #1;
            ok = (port == 0) ? rel0_ready : rel1_ready;
            @(posedge clk);
        end while (!ok);
        #1;
        rel0_valid = 1'b0;
        rel1_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(free_count == CW'(N), "R1 count", free_count, N);
        check(err_flag == 1'b0, "R1 err", err_flag, 0);
        check(alloc_full == 1'b0 && alloc_ready, "R1 full", alloc_full, 0);
    endtask

    task automatic t_alloc_order();
        logic [AW-1:0] a;
        logic f;
        for (int k = 0; k < 3; k++) begin
            alloc_one(a, f);
            check(!f && a == AW'(k << SH), "R2 lowest slot", a, k << SH);
        end
        @(negedge clk);
        check(free_count == CW'(N - 3), "R4 count after 3 claims", free_count, N - 3);
    endtask

    task automatic t_release_reuse();
        logic [AW-1:0] a;
        logic f;
        release_on(1, AW'(1 << SH));
        @(negedge clk);
        check(free_count == CW'(N - 2), "R5 count after release", free_count, N - 2);
        alloc_one(a, f);
        check(!f && a == AW'(1 << SH), "R5 released slot reused", a, 1 << SH);
    endtask

    task automatic t_fill();
        logic [AW-1:0] a;
        logic f;
        bit all_ok = 1'b1;
        longint bad_a = 0;
        longint bad_e = 0;
        for (int k = 3; k < N; k++) begin
            alloc_one(a, f);
            if (f || a != AW'(k << SH)) begin
                if (all_ok) begin bad_a = a; bad_e = k << SH; end
                all_ok = 1'b0;
            end
        end
        check(all_ok, "R2 fill ascending", bad_a, bad_e);
        alloc_one(a, f);
        check(f == 1'b1, "R3 full flag", f, 1);
        @(negedge clk);
        check(free_count == '0, "R3 nothing claimed", free_count, 0);
    endtask

    task automatic t_both_ports();
        logic [AW-1:0] a;
        logic f;
        @(negedge clk);
        rel0_valid = 1'b1; rel0_addr = AW'(5 << SH);
        rel1_valid = 1'b1; rel1_addr = AW'(9 << SH);
        #1;
        check(rel0_ready && !rel1_ready, "R6 port0 wins", {rel0_ready, rel1_ready}, 2'b10);
        @(posedge clk);
        #1;
        rel0_valid = 1'b0;
        #1;
        check(rel1_ready == 1'b1, "R6 port1 later accepted", rel1_ready, 1);
        @(posedge clk);
        #1;
        rel1_valid = 1'b0;
        @(negedge clk);
        check(free_count == CW'(2), "R6 both applied", free_count, 2);
        alloc_one(a, f);
        check(!f && a == AW'(5 << SH), "R6 slot5 free", a, 5 << SH);
        alloc_one(a, f);
        check(!f && a == AW'(9 << SH), "R6 slot9 free", a, 9 << SH);
    endtask

    task automatic t_same_cycle();
        logic [AW-1:0] a;
        logic f;
        release_on(0, AW'(10 << SH));
        @(negedge clk);
        alloc_valid = 1'b1;
        rel0_valid  = 1'b1; rel0_addr = AW'(3 << SH);
        #1;
        a = alloc_addr;
        f = alloc_full;
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
        rel0_valid  = 1'b0;
        check(!f && a == AW'(10 << SH), "R7 alloc ignores same-cycle release", a, 10 << SH);
        @(negedge clk);
        check(free_count == CW'(1), "R7 both applied", free_count, 1);
        alloc_one(a, f);
        check(!f && a == AW'(3 << SH), "R7 freed slot later", a, 3 << SH);
    endtask

    task automatic t_bad_release();
        logic [AW-1:0] a;
        logic f;
        release_on(0, AW'(3 << SH));
        @(negedge clk);
        check(err_flag == 1'b0 && free_count == CW'(1), "R5 good release", free_count, 1);
        release_on(1, AW'(3 << SH));
        @(negedge clk);
        check(err_flag == 1'b1, "R8 double release error", err_flag, 1);
        check(free_count == CW'(1), "R8 count unchanged", free_count, 1);
        release_on(0, AW'((4 << SH) + 4));
        @(negedge clk);
        check(free_count == CW'(1), "R8 misaligned ignored", free_count, 1);
        release_on(1, AW'(N << SH));
        @(negedge clk);
        check(free_count == CW'(1), "R8 out of range ignored", free_count, 1);
        alloc_one(a, f);
        check(!f && a == AW'(3 << SH), "R8 map intact", a, 3 << SH);
        alloc_one(a, f);
        check(f == 1'b1, "R8 slot4 still used", f, 1);
        release_on(0, AW'(4 << SH));
        @(negedge clk);
        check(err_flag == 1'b1, "R9 err sticky", err_flag, 1);
        check(free_count == CW'(1), "R9 good release still works", free_count, 1);
    endtask

    initial begin
        t_reset();
        t_alloc_order();
        t_release_reuse();
        t_fill();
        t_both_ports();
        t_same_cycle();
        t_bad_release();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule